// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a two-part logical address, a segment number plus an offset within that segment, into a physical address. It keeps a small segment table in flops. Each entry describes one segment: where the segment starts in physical memory, how long it is, whether it is in use, and which kinds of access (read, write, instruction fetch) it allows. A separate count register says how many table entries the current program may use.

Software-side logic fills the table and the count through a configuration port, one write per cycle. The requesting side presents a segment number, an offset and an access kind. One cycle later the block returns one of two results. The first is a physical address equal to the segment start plus the offset. The second is a trap with a code that names the first legality check that failed. The checks run in a fixed order: segment number against the count, the in-use bit, the offset against the segment length, and then the access rights.

Top module: `seg_xlat_unit`

## Requirements
- R1: After a synchronous reset, `rsp_valid` is low, the segment count is zero and every entry is marked unused, so the first request traps with cause 1.
- R2: A request presented with `req_valid` high in one cycle produces `rsp_valid` high in the following cycle; back-to-back requests give back-to-back responses.
- R3: A segment number not below the segment count traps with cause 1, whatever the contents of that table entry.
- R4: A request to an in-range entry whose in-use bit is 0 traps with cause 2.
- R5: An offset equal to or greater than the segment length traps with cause 3; offset = length - 1 is legal.
- R6: The access kind is encoded as 0 read, 1 write, 2 fetch, 3 reserved. Read needs permission bit 0, write needs bit 1 and fetch needs bit 2; the reserved kind is never allowed. A denied access traps with cause 4.
- R7: When all checks pass, `rsp_ok` is 1, `rsp_cause` is 0 and `rsp_paddr` is (start + offset) modulo 2^PA_W.
- R8: When several checks fail, the lowest nonzero cause code is reported. The codes are 0 none, 1 segment out of range, 2 unused segment, 3 offset too large and 4 access denied.
- R9: On a trap, `rsp_ok` is 0 and `rsp_paddr` is 0.
- R10: A configuration write takes effect for requests presented in the next cycle. A request presented in the same cycle as the write still sees the old contents.
- R11: In a cycle after one with no request, `rsp_valid`, `rsp_ok`, `rsp_cause` and `rsp_paddr` are all 0.
- R12: With `cfg_sel` = 0 a write loads the entry selected by `cfg_seg` and leaves other entries unchanged. With `cfg_sel` = 1 it loads the segment count from `cfg_len`, which can range from 0 to 2^SEG_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 writes a table entry, 1 writes the segment count |
| cfg_seg | input | SEG_W | Entry index for an entry write |
| cfg_base | input | PA_W | Segment start address |
| cfg_limit | input | OFF_W+1 | Segment length |
| cfg_valid | input | 1 | In-use bit for the entry |
| cfg_perm | input | 3 | Access rights: bit 0 read, bit 1 write, bit 2 fetch |
| cfg_len | input | SEG_W+1 | New segment count |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access kind (0 read, 1 write, 2 fetch, 3 reserved) |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_paddr | output | PA_W | Physical address, 0 on a trap |
| rsp_cause | output | 3 | Trap cause code |

## Verification
The hardest situation to reach from the ports is a configuration write and a request landing on the same clock edge. This is where the old-versus-new table contents are decided. The stimulus drives a count write together with a request to the segment it would admit, and an in-use write together with a request to that entry. In both cases it then repeats the request one cycle later and expects the opposite outcome. Priority between causes is reached with entries set up to fail two checks at once: an unused segment with a large offset, and a fetch-only segment with an oversized read.

// File: rtl/seg_xlat_pkg.sv
// Shared encodings for the segmented address translator.
// Assumes: cause codes and access kinds are fixed by the block's requirements.
package seg_xlat_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_RANGE   = 3'd1,
        CAUSE_UNUSED  = 3'd2,
        CAUSE_LIMIT   = 3'd3,
        CAUSE_DENIED  = 3'd4
    } trap_cause_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    localparam int PERM_BITS  = 3;
    localparam int PERM_READ  = 0;
    localparam int PERM_WRITE = 1;
    localparam int PERM_FETCH = 2;

endpackage

// File: rtl/seg_table.sv
// Segment table storage: one flop entry per segment plus the count register.
// What it does: accepts one configuration write per cycle, either to a single
// entry or to the count register, and presents the entry selected by rd_seg
// combinationally.
// Assumes: synchronous active-low reset; reset marks every entry unused and
// zeroes the count.
module seg_table #(
    parameter int SEG_W = 3,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cfg_sel,
    input  logic [SEG_W-1:0]     cfg_seg,
    input  logic [PA_W-1:0]      cfg_base,
    input  logic [OFF_W:0]       cfg_limit,
    input  logic                 cfg_valid,
    input  logic [2:0]           cfg_perm,
    input  logic [SEG_W:0]       cfg_len,
    input  logic [SEG_W-1:0]     rd_seg,
    output logic [PA_W-1:0]      rd_base,
    output logic [OFF_W:0]       rd_limit,
    output logic                 rd_valid,
    output logic [2:0]           rd_perm,
    output logic [SEG_W:0]       len_q
);

    localparam int N_SEG = 1 << SEG_W;

    logic [PA_W-1:0]  base_arr  [N_SEG];
    logic [OFF_W:0]   limit_arr [N_SEG];
    logic             valid_arr [N_SEG];
    logic [2:0]       perm_arr  [N_SEG];

    // Count register: loaded by a write with cfg_sel set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (cfg_we && cfg_sel) begin
            len_q <= cfg_len;
        end
    end

    for (genvar g = 0; g < N_SEG; g++) begin : g_entry
        logic [PA_W-1:0] ent_base;
        logic [OFF_W:0]  ent_limit;
        logic            ent_valid;
        logic [2:0]      ent_perm;
        logic            hit;

        assign hit = cfg_we && !cfg_sel && (cfg_seg == SEG_W'(g));

        // One entry: reloaded only when the write addresses this index.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_base  <= '0;
                ent_limit <= '0;
                ent_valid <= 1'b0;
                ent_perm  <= '0;
            end else if (hit) begin
                ent_base  <= cfg_base;
                ent_limit <= cfg_limit;
                ent_valid <= cfg_valid;
                ent_perm  <= cfg_perm;
            end
        end

        assign base_arr[g]  = ent_base;
        assign limit_arr[g] = ent_limit;
        assign valid_arr[g] = ent_valid;
        assign perm_arr[g]  = ent_perm;
    end

    // Read port: select the entry named by the request.
    always_comb begin
        rd_base  = base_arr[rd_seg];
        rd_limit = limit_arr[rd_seg];
        rd_valid = valid_arr[rd_seg];
        rd_perm  = perm_arr[rd_seg];
    end

endmodule

// File: rtl/seg_check.sv
// Legality checks and address sum for one request.
// What it does: evaluates range, in-use, length and rights checks in
// priority order and forms start + offset, all combinationally.
// Assumes: PA_W >= OFF_W; the sum wraps modulo 2^PA_W.
module seg_check
    import seg_xlat_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input  logic [SEG_W-1:0] req_seg,
    input  logic [OFF_W-1:0] req_off,
    input  logic [1:0]       req_acc,
    input  logic [SEG_W:0]   len_q,
    input  logic [PA_W-1:0]  ent_base,
    input  logic [OFF_W:0]   ent_limit,
    input  logic             ent_valid,
    input  logic [2:0]       ent_perm,
    output logic [2:0]       cause,
    output logic [PA_W-1:0]  paddr
);

    logic in_range;
    logic off_ok;
    logic rights_ok;

    // Individual check results.
    always_comb begin
        in_range = ({1'b0, req_seg} < len_q);
        off_ok   = ({1'b0, req_off} < ent_limit);
        unique case (acc_kind_e'(req_acc))
            ACC_READ:  rights_ok = ent_perm[PERM_READ];
            ACC_WRITE: rights_ok = ent_perm[PERM_WRITE];
            ACC_FETCH: rights_ok = ent_perm[PERM_FETCH];
            default:   rights_ok = 1'b0;
        endcase
    end

    // Priority encode: the first failing check wins.
    always_comb begin
        if (!in_range) begin
            cause = CAUSE_RANGE;
        end else if (!ent_valid) begin
            cause = CAUSE_UNUSED;
        end else if (!off_ok) begin
            cause = CAUSE_LIMIT;
        end else if (!rights_ok) begin
            cause = CAUSE_DENIED;
        end else begin
            cause = CAUSE_NONE;
        end
    end

    // Physical address: segment start plus zero-extended offset.
    always_comb begin
        paddr = ent_base + PA_W'(req_off);
    end

endmodule

// File: rtl/seg_resp_reg.sv
// Response register stage.
// What it does: captures the check result one cycle after a request, and
// forces the address to zero on a trap and all fields to zero when idle.
// Assumes: synchronous active-low reset.
module seg_resp_reg #(
    parameter int PA_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      cause,
    input  logic [PA_W-1:0] paddr,
    output logic            rsp_valid,
    output logic            rsp_ok,
    output logic [2:0]      rsp_cause,
    output logic [PA_W-1:0] rsp_paddr
);

    logic pass;

    assign pass = (cause == 3'd0);

    // Output stage: one register between the checks and the ports.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_cause <= '0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= 1'b1;
            rsp_ok    <= pass;
            rsp_cause <= cause;
            rsp_paddr <= pass ? paddr : '0;
        end
    end

endmodule

// File: rtl/seg_xlat_unit.sv
// Segmented address translator top.
// What it does: table storage, checks and response register in sequence;
// a request yields a result one cycle later.
// Assumes: a configuration write and a request in the same cycle see the
// table as it was before the write.
module seg_xlat_unit #(
    parameter int SEG_W = 3,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [SEG_W-1:0] cfg_seg,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [OFF_W:0]   cfg_limit,
    input  logic             cfg_valid,
    input  logic [2:0]       cfg_perm,
    input  logic [SEG_W:0]   cfg_len,
    input  logic             req_valid,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [OFF_W-1:0] req_off,
    input  logic [1:0]       req_acc,
    output logic             rsp_valid,
    output logic             rsp_ok,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [2:0]       rsp_cause
);

    logic [PA_W-1:0]  ent_base;
    logic [OFF_W:0]   ent_limit;
    logic             ent_valid;
    logic [2:0]       ent_perm;
    logic [SEG_W:0]   seg_len;
    logic [2:0]       chk_cause;
    logic [PA_W-1:0]  chk_paddr;

    seg_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_seg   (cfg_seg),
        .cfg_base  (cfg_base),
        .cfg_limit (cfg_limit),
        .cfg_valid (cfg_valid),
        .cfg_perm  (cfg_perm),
        .cfg_len   (cfg_len),
        .rd_seg    (req_seg),
        .rd_base   (ent_base),
        .rd_limit  (ent_limit),
        .rd_valid  (ent_valid),
        .rd_perm   (ent_perm),
        .len_q     (seg_len)
    );

    seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_check (
        .req_seg   (req_seg),
        .req_off   (req_off),
        .req_acc   (req_acc),
        .len_q     (seg_len),
        .ent_base  (ent_base),
        .ent_limit (ent_limit),
        .ent_valid (ent_valid),
        .ent_perm  (ent_perm),
        .cause     (chk_cause),
        .paddr     (chk_paddr)
    );

    seg_resp_reg #(.PA_W(PA_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .cause     (chk_cause),
        .paddr     (chk_paddr),
        .rsp_valid (rsp_valid),
        .rsp_ok    (rsp_ok),
        .rsp_cause (rsp_cause),
        .rsp_paddr (rsp_paddr)
    );

endmodule

// File: rtl/seg_xlat_checker.sv
// Property checker for the segmented address translator, bound to the top.
// Assumes: synchronous active-low reset on rst_n.
module seg_xlat_checker #(
    parameter int SEG_W = 3,
    parameter int PA_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [SEG_W-1:0] req_seg,
    input logic [SEG_W:0]   seg_len,
    input logic             rsp_valid,
    input logic             rsp_ok,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic [2:0]       rsp_cause
);

    // R1: the count register is empty in the first cycle out of reset.
    p_len_cleared_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (seg_len == '0));

    // R2: every request is answered in the next cycle.
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R3: a segment number at or above the count traps with cause 1.
    p_range_trap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_seg} >= seg_len)) |=> (rsp_cause == 3'd1));

    // R7: success carries a clean cause and a strobe.
    p_ok_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ok |-> (rsp_valid && rsp_cause == 3'd0));

    // R8: only the defined codes appear.
    p_cause_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cause <= 3'd4);

    // R9: a trap never carries an address.
    p_trap_noaddr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause != 3'd0) |-> (!rsp_ok && rsp_paddr == '0));

    // R11: no request leaves all outputs at zero next cycle.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_ok && rsp_cause == 3'd0 && rsp_paddr == '0));

endmodule

bind seg_xlat_unit seg_xlat_checker #(.SEG_W(SEG_W), .PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_seg   (req_seg),
    .seg_len   (seg_len),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .rsp_paddr (rsp_paddr),
    .rsp_cause (rsp_cause)
);

// File: tb/seg_xlat_unit_test.sv
module seg_xlat_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int SEG_W = 3;
    localparam int OFF_W = 12;
    localparam int PA_W  = 16;
    localparam int N_SEG = 1 << SEG_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_sel = 1'b0;
    logic [SEG_W-1:0] cfg_seg = '0;
    logic [PA_W-1:0]  cfg_base = '0;
    logic [OFF_W:0]   cfg_limit = '0;
    logic             cfg_valid = 1'b0;
    logic [2:0]       cfg_perm = '0;
    logic [SEG_W:0]   cfg_len = '0;
    logic             req_valid = 1'b0;
    logic [SEG_W-1:0] req_seg = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic [1:0]       req_acc = '0;
    logic             rsp_valid;
    logic             rsp_ok;
    logic [PA_W-1:0]  rsp_paddr;
    logic [2:0]       rsp_cause;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [2:0]      cause;
        logic [PA_W-1:0] pa;
        string           tag;
    } exp_t;
    exp_t sb_q[$];

    // Bench-side model of the table, from the requirements.
    logic [PA_W-1:0] m_base  [N_SEG];
    logic [OFF_W:0]  m_limit [N_SEG];
    logic            m_valid [N_SEG];
    logic [2:0]      m_perm  [N_SEG];
    int              m_len;

    always #(CLK_PERIOD / 2) clk = ~clk;

    seg_xlat_unit #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_seg(cfg_seg),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_valid(cfg_valid),
        .cfg_perm(cfg_perm), .cfg_len(cfg_len),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
        .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_paddr(rsp_paddr),
        .rsp_cause(rsp_cause)
    );

    // Expected outcome: checks in priority order R3, R4, R5, R6; else R7.
    function automatic exp_t predict(input int seg, input int off, input int acc, input string tag);
        exp_t e;
        logic ok_rights;
        e.tag = tag;
        e.pa  = '0;
        ok_rights = (acc == 0) ? m_perm[seg][0] :
                    (acc == 1) ? m_perm[seg][1] :
                    (acc == 2) ? m_perm[seg][2] : 1'b0;
        if (seg >= m_len)                   e.cause = 3'd1;
        else if (!m_valid[seg])             e.cause = 3'd2;
        else if (off >= int'(m_limit[seg])) e.cause = 3'd3;
        else if (!ok_rights)                e.cause = 3'd4;
        else begin
            e.cause = 3'd0;
            e.pa    = m_base[seg] + PA_W'(off);
        end
        return e;
    endfunction

    task automatic check(input bit cond, input string tag, input string what);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    // Driver: request; expected value pushed once the edge has happened.
    task automatic xlate(input int seg, input int off, input int acc, input string tag);
        exp_t e;
        @(negedge clk);
        e = predict(seg, off, acc, tag);
        req_valid = 1'b1;
        req_seg   = SEG_W'(seg);
        req_off   = OFF_W'(off);
        req_acc   = 2'(acc);
        @(posedge clk);
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            cfg_we    = 1'b0;
            @(posedge clk);
        end
    endtask

    task automatic wr_entry(input int seg, input int base, input int lim, input bit vld, input int perm);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_seg = SEG_W'(seg);
        cfg_base = PA_W'(base); cfg_limit = (OFF_W + 1)'(lim);
        cfg_valid = vld; cfg_perm = 3'(perm);
        @(posedge clk);
        m_base[seg] = PA_W'(base); m_limit[seg] = (OFF_W + 1)'(lim);
        m_valid[seg] = vld; m_perm[seg] = 3'(perm);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_len(input int len);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_len = (SEG_W + 1)'(len);
        @(posedge clk);
        m_len = len;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R10: length write and request on the same edge; request sees old count.
    task automatic len_with_req(input int len, input int seg, input int off, input int acc);
        exp_t e;
        @(negedge clk);
        e = predict(seg, off, acc, "R10 same-cycle count write");
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_len = (SEG_W + 1)'(len);
        req_valid = 1'b1; req_seg = SEG_W'(seg); req_off = OFF_W'(off); req_acc = 2'(acc);
        @(posedge clk);
        sb_q.push_back(e);
        m_len = len;
        @(negedge clk);
        cfg_we = 1'b0;
        req_valid = 1'b0;
    endtask

    // R10: entry write and request on the same edge; request sees old entry.
    task automatic entry_with_req(input int seg, input int base, input int lim, input int perm, input int off, input int acc);
        exp_t e;
        @(negedge clk);
        e = predict(seg, off, acc, "R10 same-cycle entry write");
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_seg = SEG_W'(seg);
        cfg_base = PA_W'(base); cfg_limit = (OFF_W + 1)'(lim);
        cfg_valid = 1'b1; cfg_perm = 3'(perm);
        req_valid = 1'b1; req_seg = SEG_W'(seg); req_off = OFF_W'(off); req_acc = 2'(acc);
        @(posedge clk);
        sb_q.push_back(e);
        m_base[seg] = PA_W'(base); m_limit[seg] = (OFF_W + 1)'(lim);
        m_valid[seg] = 1'b1; m_perm[seg] = 3'(perm);
        @(negedge clk);
        cfg_we = 1'b0;
        req_valid = 1'b0;
    endtask

    // Monitor: compare each response with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2", "response with nothing expected");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(rsp_cause == e.cause && rsp_ok == (e.cause == 3'd0) && rsp_paddr == e.pa,
                      e.tag,
                      $sformatf("actual cause=%0d ok=%0b pa=%h expected cause=%0d ok=%0b pa=%h",
                                rsp_cause, rsp_ok, rsp_paddr, e.cause, (e.cause == 3'd0), e.pa));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N_SEG; i++) begin
            m_base[i] = '0; m_limit[i] = '0; m_valid[i] = 1'b0; m_perm[i] = '0;
        end
        m_len = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1", $sformatf("actual rsp_valid=%0b expected 0", rsp_valid));

        // R1: nothing loaded, count is zero.
        xlate(0, 0, 0, "R1 empty table traps");
        idle(1);

        // Load the table.
        wr_len(4);
        wr_entry(0, 'h1000, 'h100, 1'b1, 3'b011);
        wr_entry(1, 'hF800, 'h1000, 1'b1, 3'b111);
        wr_entry(2, 'h2000, 'h10, 1'b0, 3'b111);
        wr_entry(3, 'h3000, 'h20, 1'b1, 3'b100);
        wr_entry(5, 'h5000, 'h100, 1'b1, 3'b111);
        wr_entry(7, 'h7000, 'h100, 1'b0, 3'b111);

        // Back-to-back stream (R2).
        xlate(0, 'h0FF, 0, "R5 last legal offset");
        xlate(0, 'h100, 0, "R5 offset equals length");
        xlate(0, 'h000, 1, "R6 write allowed");
        xlate(0, 'h004, 2, "R6 fetch denied");
        xlate(0, 'h005, 3, "R6 reserved kind denied");
        xlate(1, 'hFFF, 2, "R7 sum wraps");
        xlate(1, 'h010, 0, "R7 plain success");
        xlate(2, 'h000, 0, "R4 unused segment");
        xlate(2, 'h050, 2, "R8 unused beats length");
        xlate(3, 'h010, 2, "R6 fetch-only allowed");
        xlate(3, 'h010, 0, "R6 read on fetch-only");
        xlate(3, 'h040, 0, "R8 length beats rights");
        xlate(5, 'h000, 0, "R3 valid entry past count");
        xlate(7, 'h000, 0, "R3 top segment past count");
        idle(1);
        @(negedge clk);
        check(rsp_valid == 1'b0 && rsp_paddr == '0 && rsp_cause == '0, "R11",
              $sformatf("actual valid=%0b pa=%h cause=%0d expected 0 0 0", rsp_valid, rsp_paddr, rsp_cause));

        // R10 and R12.
        len_with_req(6, 5, 'h10, 0);
        xlate(5, 'h10, 0, "R10 count visible next cycle");
        entry_with_req(2, 'h2200, 'h10, 3'b001, 'h4, 0);
        xlate(2, 'h4, 0, "R10 entry visible next cycle");
        xlate(0, 'h0FF, 0, "R12 other entry unchanged");
        wr_len(8);
        xlate(7, 'h0, 0, "R12 full count admits top segment");
        xlate(6, 'h0, 1, "R4 never-loaded entry unused");
        idle(3);

        check(sb_q.size() == 0, "R2", $sformatf("actual pending=%0d expected 0", sb_q.size()));
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule